// File: doc/BRIEF.md
# Flash Write Protection Arbiter

This block sits between a host register interface and a serial flash command sequencer. It vets each requested read, write or erase cycle before the sequencer sees it. A cycle is described by a type, a start address and a byte count, and is launched by a one-cycle go strobe. The arbiter either forwards the cycle on a one-cycle grant pulse, with the command fields copied, or refuses it. A refusal is a one-cycle block pulse that also sets a sticky error flag.

Software controls the arbiter through a small register file. The control word holds:
- a write-enable bit;
- a lock bit that makes every rising edge of the write enable raise a management interrupt request, so that a handler can revoke the enable;
- a bit that confines firmware-region writes to times when all processors are in management mode;
- a configuration lock that freezes the protected ranges;
- the error flag.

Each protected range covers a span of 4 KiB pages and can be marked write-protected, read-protected or both. The lock bit and the configuration lock are sticky: only reset clears them.

Top module: `flash_guard`

## Requirements
- R1: After reset, every control bit, every range register and every output is 0.
- R2: A go strobe sampled at a clock edge yields, in the following cycle, exactly one of a one-cycle `seq_go` or a one-cycle `blocked`. On a grant, `seq_type`, `seq_addr` and `seq_cnt` carry the command's fields. `seq_cnt` stays count minus one, so 63 means 64 bytes.
- R3: Cycle type codes are 0 read, 2 write and 3 erase. Code 1 is reserved and always refused.
- R4: Write and erase cycles are refused while the write-enable bit (control bit 0, register address 0) is 0.
- R5: When the lock bit is 1 after a control write that takes the write enable from 0 to 1, `mgmt_irq` pulses for exactly one cycle. It does not pulse when the enable was already 1, nor when the lock bit is 0.
- R6: The lock bit (control bit 1) can be set by software, but writing 0 to it has no effect.
- R7: Range i lives at register address 8+i. Bits 11:0 hold the base page, bits 23:12 the inclusive limit page (page = address bits 23:12), bit 30 is read-protect and bit 31 is write-protect. A write or erase is refused when any page it touches lies inside a write-protected range. A write touches pages from addr to addr+count; an erase touches the page of addr.
- R8: A read is never refused by the write enable or by write-protection. It is refused only when a page from addr to addr+count lies in a read-protected range.
- R9: The configuration lock (control bit 3) is sticky once set. While it is 1, writes to range registers have no effect.
- R10: While the management-only bit (control bit 2) is 1, a write or erase touching a firmware page (0x800 to 0xFFF by default) is refused unless `all_in_mm` is 1. Reads are unaffected.
- R11: The error flag (control bit 4, output `access_err`) is set in the cycle that follows a refused go strobe. Writing 1 to it clears it; a refusal in the same cycle takes precedence.
- R12: `reg_rdata` shows, one cycle later, the register chosen by `reg_addr`. The control word reads as {27'b0, error, config lock, management-only, lock, write enable}, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address for write and readback |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered readback data |
| cmd_go | input | 1 | One-cycle cycle request strobe |
| cmd_type | input | 2 | Cycle type code |
| cmd_addr | input | 24 | Flash start address |
| cmd_cnt | input | 6 | Byte count minus one |
| all_in_mm | input | 1 | All processors are in management mode |
| seq_go | output | 1 | Grant pulse to the sequencer |
| seq_type | output | 2 | Granted cycle type |
| seq_addr | output | 24 | Granted start address |
| seq_cnt | output | 6 | Granted byte count minus one |
| blocked | output | 1 | Refusal pulse |
| access_err | output | 1 | Sticky access-error flag |
| mgmt_irq | output | 1 | Management interrupt request pulse |

## Verification
Cycles are issued in every type, with the write enable both off and on, so that gating by type can be told apart from gating by the enable. Writes are placed so that they end one byte short of a protected page and so that they spill into it, and erases are aimed at the last protected page and the first free one. These show that the whole byte span is checked and that the limit is inclusive. Reads go against write-only and read-only ranges, which separates the two protection kinds. Firmware-page writes are tried with the management-mode input low and high, and around the firmware boundary. Locks are probed by writing zeros to sticky bits and to frozen ranges and then reading the registers back.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef enum logic [1:0] {
    CYC_READ  = 2'd0,
    CYC_RSVD  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_ERASE = 2'd3
  } cyc_e;

  localparam int B_WREN = 0;
  localparam int B_LOCK = 1;
  localparam int B_MMO  = 2;
  localparam int B_CFG  = 3;
  localparam int B_ERR  = 4;
  localparam int CTRL_BITS = 5;

  localparam int REG_AW   = 4;
  localparam int REG_DW   = 32;
  localparam int RNG_BASE = 8;
  localparam int PAGE_SH  = 12;
  localparam int RP_BIT   = 30;
  localparam int WP_BIT   = 31;
endpackage

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ctrl_wr,
  input  logic [CTRL_BITS-1:0] wbits,
  input  logic                 refuse,
  output logic                 wren,
  output logic                 lock_en,
  output logic                 mm_only,
  output logic                 cfg_lock,
  output logic                 acc_err,
  output logic                 irq
);
  logic wren_n, lock_n;

  always_comb begin
    wren_n = ctrl_wr ? wbits[B_WREN] : wren;
    lock_n = lock_en | (ctrl_wr & wbits[B_LOCK]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wren     <= 1'b0;
      lock_en  <= 1'b0;
      mm_only  <= 1'b0;
      cfg_lock <= 1'b0;
      acc_err  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      wren     <= wren_n;
      lock_en  <= lock_n;
      if (ctrl_wr) mm_only <= wbits[B_MMO];
      cfg_lock <= cfg_lock | (ctrl_wr & wbits[B_CFG]);
      acc_err  <= refuse | (acc_err & ~(ctrl_wr & wbits[B_ERR]));
      irq      <= wren_n & ~wren & lock_n;
    end
  end
endmodule

// File: rtl/fg_range_bank.sv
module fg_range_bank
  import fg_pkg::*;
#(
  parameter int NR   = 4,
  parameter int PG_W = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NR-1:0]      wr_sel,
  input  logic [REG_DW-1:0]  wdata,
  input  logic               cfg_lock,
  input  logic [PG_W-1:0]    pg_lo,
  input  logic [PG_W:0]      pg_hi,
  output logic               wp_hit,
  output logic               rp_hit,
  output logic [NR*REG_DW-1:0] ranges_flat
);
  logic [NR-1:0] wp_v, rp_v;

  for (genvar i = 0; i < NR; i++) begin : g_rng
    logic [REG_DW-1:0] word;
    logic [PG_W-1:0]   base, limit;
    logic              overlap;

    always_ff @(posedge clk) begin
      if (rst) word <= '0;
      else if (wr_sel[i] && !cfg_lock) word <= wdata;
    end

    assign base    = word[PG_W-1:0];
    assign limit   = word[2*PG_W-1:PG_W];
    assign overlap = (pg_lo <= limit) && (pg_hi >= {1'b0, base});
    assign wp_v[i] = word[WP_BIT] & overlap;
    assign rp_v[i] = word[RP_BIT] & overlap;
    assign ranges_flat[i*REG_DW +: REG_DW] = word;
  end

  assign wp_hit = |wp_v;
  assign rp_hit = |rp_v;
endmodule

// File: rtl/fg_gate.sv
module fg_gate
  import fg_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 6,
  parameter int FW_LO  = 'h800,
  parameter int FW_HI  = 'hFFF,
  localparam int PG_W  = ADDR_W - PAGE_SH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_go,
  input  logic [1:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic              wren,
  input  logic              mm_only,
  input  logic              all_in_mm,
  input  logic              wp_hit,
  input  logic              rp_hit,
  output logic [PG_W-1:0]   pg_lo,
  output logic [PG_W:0]     pg_hi,
  output logic              refuse,
  output logic              seq_go,
  output logic [1:0]        seq_type,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [CNT_W-1:0]  seq_cnt,
  output logic              blocked
);
  logic [ADDR_W:0] end_addr;
  logic is_rd, is_wr, fw_hit, ok;

  always_comb begin
    end_addr = {1'b0, cmd_addr} + (ADDR_W+1)'(cmd_cnt);
    pg_lo    = cmd_addr[ADDR_W-1:PAGE_SH];
    pg_hi    = (cmd_type == CYC_ERASE) ? {1'b0, pg_lo} : end_addr[ADDR_W:PAGE_SH];
    is_rd    = (cmd_type == CYC_READ);
    is_wr    = (cmd_type == CYC_WRITE) || (cmd_type == CYC_ERASE);
    fw_hit   = (pg_lo <= PG_W'(FW_HI)) && (pg_hi >= (PG_W+1)'(FW_LO));
    if (is_rd) ok = !rp_hit;
    else       ok = is_wr && wren && !wp_hit && !(mm_only && fw_hit && !all_in_mm);
    refuse   = cmd_go && !ok;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_go   <= 1'b0;
      blocked  <= 1'b0;
      seq_type <= '0;
      seq_addr <= '0;
      seq_cnt  <= '0;
    end else begin
      seq_go  <= cmd_go && ok;
      blocked <= refuse;
      if (cmd_go && ok) begin
        seq_type <= cmd_type;
        seq_addr <= cmd_addr;
        seq_cnt  <= cmd_cnt;
      end
    end
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int CNT_W      = 6,
  parameter int NUM_RANGES = 4,
  parameter int FW_LO      = 'h800,
  parameter int FW_HI      = 'hFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [3:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmd_go,
  input  logic [1:0]        cmd_type,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [CNT_W-1:0]  cmd_cnt,
  input  logic              all_in_mm,
  output logic              seq_go,
  output logic [1:0]        seq_type,
  output logic [ADDR_W-1:0] seq_addr,
  output logic [CNT_W-1:0]  seq_cnt,
  output logic              blocked,
  output logic              access_err,
  output logic              mgmt_irq
);
  localparam int PG_W = ADDR_W - PAGE_SH;

  logic wren, lock_en, mm_only, cfg_lock, refuse, wp_hit, rp_hit;
  logic [PG_W-1:0] pg_lo;
  logic [PG_W:0]   pg_hi;
  logic [NUM_RANGES-1:0] wr_sel;
  logic [NUM_RANGES*REG_DW-1:0] ranges_flat;
  logic [REG_DW-1:0] rdata_n;

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_sel
    assign wr_sel[i] = reg_we && (reg_addr == REG_AW'(RNG_BASE + i));
  end

  fg_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ctrl_wr(reg_we && (reg_addr == '0)),
    .wbits(reg_wdata[CTRL_BITS-1:0]),
    .refuse(refuse),
    .wren(wren), .lock_en(lock_en), .mm_only(mm_only),
    .cfg_lock(cfg_lock), .acc_err(access_err), .irq(mgmt_irq)
  );

  fg_range_bank #(.NR(NUM_RANGES), .PG_W(PG_W)) u_bank (
    .clk(clk), .rst(rst), .wr_sel(wr_sel), .wdata(reg_wdata),
    .cfg_lock(cfg_lock), .pg_lo(pg_lo), .pg_hi(pg_hi),
    .wp_hit(wp_hit), .rp_hit(rp_hit), .ranges_flat(ranges_flat)
  );

  fg_gate #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .FW_LO(FW_LO), .FW_HI(FW_HI)) u_gate (
    .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_type(cmd_type),
    .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt), .wren(wren), .mm_only(mm_only),
    .all_in_mm(all_in_mm), .wp_hit(wp_hit), .rp_hit(rp_hit),
    .pg_lo(pg_lo), .pg_hi(pg_hi), .refuse(refuse), .seq_go(seq_go),
    .seq_type(seq_type), .seq_addr(seq_addr), .seq_cnt(seq_cnt),
    .blocked(blocked)
  );

  always_comb begin
    rdata_n = '0;
    if (reg_addr == '0)
      rdata_n = {27'b0, access_err, cfg_lock, mm_only, lock_en, wren};
    for (int i = 0; i < NUM_RANGES; i++)
      if (reg_addr == REG_AW'(RNG_BASE + i)) rdata_n = ranges_flat[i*REG_DW +: REG_DW];
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rdata_n;
  end
endmodule

// File: rtl/fg_checker.sv
module fg_checker
  import fg_pkg::*;
#(
  parameter int NR = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_go,
  input logic [1:0]        cmd_type,
  input logic              seq_go,
  input logic              blocked,
  input logic              access_err,
  input logic              mgmt_irq,
  input logic              wren,
  input logic              lock_en,
  input logic              cfg_lock,
  input logic [NR*REG_DW-1:0] ranges_flat
);
  p_one_outcome_r2: assert property (@(posedge clk) disable iff (rst)
    cmd_go |=> (seq_go ^ blocked));
  p_no_spurious_r2: assert property (@(posedge clk) disable iff (rst)
    !cmd_go |=> !(seq_go || blocked));
  p_rsvd_refused_r3: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_type == CYC_RSVD) |=> blocked);
  p_need_wren_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_go && cmd_type != CYC_READ && !wren) |=> !seq_go);
  p_irq_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    mgmt_irq |=> !mgmt_irq);
  p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
    mgmt_irq |-> (wren && lock_en));
  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    lock_en |=> lock_en);
  p_cfg_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_lock |=> cfg_lock);
  p_ranges_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    cfg_lock |=> $stable(ranges_flat));
  p_block_flags_r11: assert property (@(posedge clk) disable iff (rst)
    blocked |-> access_err);
endmodule

bind flash_guard fg_checker #(.NR(NUM_RANGES)) u_fg_checker (
  .clk(clk), .rst(rst), .cmd_go(cmd_go), .cmd_type(cmd_type),
  .seq_go(seq_go), .blocked(blocked), .access_err(access_err),
  .mgmt_irq(mgmt_irq), .wren(wren), .lock_en(lock_en),
  .cfg_lock(cfg_lock), .ranges_flat(ranges_flat)
);

// File: tb/test_flash_guard.sv
`timescale 1ns/1ps
module test_flash_guard;
  logic        clk = 0;
  logic        rst = 1;
  logic        reg_we = 0;
  logic [3:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        cmd_go = 0;
  logic [1:0]  cmd_type = 0;
  logic [23:0] cmd_addr = 0;
  logic [5:0]  cmd_cnt = 0;
  logic        all_in_mm = 0;
  logic        seq_go, blocked, access_err, mgmt_irq;
  logic [1:0]  seq_type;
  logic [23:0] seq_addr;
  logic [5:0]  seq_cnt;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  flash_guard i_flash_guard (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_go(cmd_go),
    .cmd_type(cmd_type), .cmd_addr(cmd_addr), .cmd_cnt(cmd_cnt),
    .all_in_mm(all_in_mm), .seq_go(seq_go), .seq_type(seq_type),
    .seq_addr(seq_addr), .seq_cnt(seq_cnt), .blocked(blocked),
    .access_err(access_err), .mgmt_irq(mgmt_irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rreg(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic issue(string req, logic [1:0] t, logic [23:0] a, logic [5:0] c, bit grant);
    @(negedge clk); cmd_go = 1; cmd_type = t; cmd_addr = a; cmd_cnt = c;
    @(negedge clk); cmd_go = 0;
    chk({req, " grant"}, {31'b0, seq_go}, {31'b0, grant});
    chk({req, " block"}, {31'b0, blocked}, {31'b0, !grant});
    if (grant) begin
      chk({req, " fields"}, {seq_type, seq_addr, seq_cnt}, {t, a, c});
    end else begin
      chk({req, " err"}, {31'b0, access_err}, 32'd1);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 outputs", {28'b0, seq_go, blocked, access_err, mgmt_irq}, 32'd0);
    rreg(4'd0, d); chk("R1 ctrl", d, 32'd0);
    rreg(4'd8, d); chk("R1 range0", d, 32'd0);
    rreg(4'd5, d); chk("R12 unmapped", d, 32'd0);
  endtask

  task automatic t_read_basic();
    issue("R2 read", 2'd0, 24'h123456, 6'd63, 1);
    @(negedge clk);
    chk("R2 single pulse", {31'b0, seq_go}, 32'd0);
  endtask

  task automatic t_no_wren();
    logic [31:0] d;
    issue("R4 write no-we", 2'd2, 24'h001000, 6'd3, 0);
    issue("R4 erase no-we", 2'd3, 24'h002000, 6'd0, 0);
    rreg(4'd0, d); chk("R11 err bit", d, 32'h10);
    wreg(4'd0, 32'h10);
    rreg(4'd0, d); chk("R11 w1c", d, 32'h0);
  endtask

  task automatic t_irq_lock();
    logic [31:0] d;
    wreg(4'd0, 32'h1);
    chk("R5 no irq without lock", {31'b0, mgmt_irq}, 32'd0);
    wreg(4'd0, 32'h0);
    wreg(4'd0, 32'h2);
    rreg(4'd0, d); chk("R6 lock set", d, 32'h2);
    wreg(4'd0, 32'h0);
    rreg(4'd0, d); chk("R6 lock sticky", d, 32'h2);
    wreg(4'd0, 32'h3);
    chk("R5 irq on rise", {31'b0, mgmt_irq}, 32'd1);
    @(negedge clk);
    chk("R5 irq one cycle", {31'b0, mgmt_irq}, 32'd0);
    wreg(4'd0, 32'h3);
    chk("R5 no irq when held", {31'b0, mgmt_irq}, 32'd0);
  endtask

  task automatic t_grant_types();
    logic [31:0] d;
    issue("R4 write granted", 2'd2, 24'h001000, 6'd0, 1);
    issue("R3 erase granted", 2'd3, 24'h002000, 6'd0, 1);
    issue("R3 reserved type", 2'd1, 24'h003000, 6'd0, 0);
    wreg(4'd0, 32'h13);
    chk("R5 no irq on rewrite", {31'b0, mgmt_irq}, 32'd0);
    rreg(4'd0, d); chk("R11 cleared", d, 32'h3);
  endtask

  task automatic t_ranges();
    logic [31:0] d;
    wreg(4'd8, 32'h8001F010);
    rreg(4'd8, d); chk("R12 range readback", d, 32'h8001F010);
    issue("R7 write below", 2'd2, 24'h00FFC0, 6'd63, 1);
    issue("R7 write spill", 2'd2, 24'h00FFE0, 6'd63, 0);
    wreg(4'd0, 32'h13);
    issue("R7 erase limit", 2'd3, 24'h01F000, 6'd0, 0);
    issue("R7 erase past", 2'd3, 24'h020000, 6'd0, 1);
    issue("R8 read in wp", 2'd0, 24'h015000, 6'd63, 1);
    wreg(4'd9, 32'h40030030);
    issue("R8 read in rp", 2'd0, 24'h030800, 6'd0, 0);
    issue("R8 read past rp", 2'd0, 24'h031000, 6'd0, 1);
    issue("R8 write in rp", 2'd2, 24'h030000, 6'd0, 1);
    wreg(4'd10, 32'h00FFF000);
    issue("R7 disabled range", 2'd2, 24'h040000, 6'd0, 1);
    wreg(4'd0, 32'h13);
  endtask

  task automatic t_mm();
    wreg(4'd0, 32'h7);
    chk("R5 no irq mm write", {31'b0, mgmt_irq}, 32'd0);
    all_in_mm = 0;
    issue("R10 fw write no-mm", 2'd2, 24'h900000, 6'd0, 0);
    issue("R10 non-fw write", 2'd2, 24'h100000, 6'd0, 1);
    issue("R10 fw read", 2'd0, 24'h900000, 6'd0, 1);
    issue("R10 below fw edge", 2'd2, 24'h7FFFC0, 6'd63, 1);
    issue("R10 spill into fw", 2'd2, 24'h7FFFE0, 6'd63, 0);
    all_in_mm = 1;
    issue("R10 fw write in mm", 2'd2, 24'h900000, 6'd0, 1);
    all_in_mm = 0;
    wreg(4'd0, 32'h17);
  endtask

  task automatic t_cfg();
    logic [31:0] d;
    wreg(4'd0, 32'hF);
    rreg(4'd0, d); chk("R9 cfg set", d, 32'hF);
    wreg(4'd8, 32'h0);
    rreg(4'd8, d); chk("R9 range frozen", d, 32'h8001F010);
    wreg(4'd0, 32'h5);
    rreg(4'd0, d); chk("R9 cfg sticky", d, 32'hF);
    wreg(4'd0, 32'h0);
    rreg(4'd0, d); chk("R6 lock kept", d, 32'hA);
    issue("R4 write after clear", 2'd2, 24'h100000, 6'd0, 0);
    rreg(4'd0, d); chk("R11 err set again", d, 32'h1A);
    wreg(4'd0, 32'h1);
    chk("R5 irq again", {31'b0, mgmt_irq}, 32'd1);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_read_basic();
    t_no_wren();
    t_irq_lock();
    t_grant_types();
    t_ranges();
    t_mm();
    t_cfg();
    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule